// File: doc/BRIEF.md
# Self-Expiring Read-Only L1 Data Cache

This block is a private, two-way set-associative L1 data cache whose lines carry an expiry time instead of a coherence state. Each line stores a tag, a 32-byte block and a timestamp. A load hits only while the shared time input is still below the line's timestamp. Once that time is reached, the line stops hitting without any message from outside, so the home node never has to send invalidations.

Loads that miss go to the home node as a line-aligned read. The home node returns the block together with a timestamp. The cache always forwards the requested word to the core. It installs the block only if that timestamp is still in the future. Stores never look at the local array: they are passed to the home node unchanged, and the core sees completion only when the home node acknowledges them. At most one home transaction is in flight, and the core is held off through its ready signal while it is pending.

Top module: `self_expiring_l1`

## Requirements
- R1: After reset, `core_req_ready` is 1 while `core_rsp_valid` and `home_req_valid` are 0, and no line is valid, so the first load to any address is sent to the home node.
- R2: A load whose tag matches a valid line with `now_time` < the stored timestamp is a hit. In the cycle after it is accepted, `core_rsp_valid` is 1 and `core_rsp_rdata` holds the addressed word, and no home request is issued. The word with index `addr[4:2]` occupies bits `[32*i+31:32*i]` of the line.
- R3: A load to a line with `now_time` >= the stored timestamp is a miss even when the tag matches. In the cycle after it is accepted, `home_req_valid` is 1 with `home_req_write` 0 and `home_req_addr` equal to the load address with bits [4:0] cleared.
- R4: A store never reads or changes the cache. In the cycle after it is accepted, the home request carries `home_req_write` 1 with the full store address and data. A line cached before the store still returns its old data on a later hit.
- R5: A store is acknowledged with `core_rsp_valid` 1 and `core_rsp_rdata` 0 only in the cycle after `home_rsp_valid`, and never earlier.
- R6: On a load miss, the cycle after `home_rsp_valid` brings `core_rsp_valid` with the requested word from `home_rsp_line`. If `now_time` < `home_rsp_ts` in the response cycle, the line is installed with that timestamp.
- R7: If a fill response has `home_rsp_ts` <= `now_time`, the requested word is still returned to the core, but the line is not installed, and a following load to it misses.
- R8: Only one home transaction is outstanding. `core_req_ready` is 0 from the acceptance of a miss or store until the cycle after its response. `home_req_valid` and its address and write flag are held steady until `home_req_ready` is seen.
- R9: A fill in a set goes to the way that already holds the same tag, if there is one. Otherwise it goes to a way that is invalid or expired, with way 0 first. Otherwise it goes to the way that was least recently hit or filled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| now_time | input | TS_W | Shared, free-running time value |
| core_req_valid | input | 1 | Core request present |
| core_req_ready | output | 1 | Cache can accept a core request |
| core_req_we | input | 1 | 1 = store, 0 = load |
| core_req_addr | input | ADDR_W | Byte address of the access |
| core_req_wdata | input | WORD_W | Store data |
| core_rsp_valid | output | 1 | One-cycle load data or store completion |
| core_rsp_rdata | output | WORD_W | Load word, 0 for a store completion |
| home_req_valid | output | 1 | Request toward the home node |
| home_req_ready | input | 1 | Home node takes the request |
| home_req_write | output | 1 | 1 = forwarded store, 0 = line read |
| home_req_addr | output | ADDR_W | Line-aligned for reads, full address for stores |
| home_req_wdata | output | WORD_W | Forwarded store data |
| home_rsp_valid | input | 1 | Fill data or store acknowledgement |
| home_rsp_line | input | LINE_BYTES*8 | Returned block |
| home_rsp_ts | input | TS_W | Expiry timestamp given to the returned block |

## Verification
A wrong internal state shows up at the ports on the next load to the affected line. A stale or missing valid bit, a bad timestamp or a wrong replacement choice turns an expected one-cycle hit into a home read, or an expected miss into a hit. Either way the symptom is visible one cycle after the load is accepted. A bench model of tags, timestamps and recency predicts hit or miss for every load. It therefore catches a wrong victim or a missed install at the first later access to that set. Errors in the handshake state appear as a ready or request-valid level that differs from the expected one in the very cycle of the mistake.

// File: rtl/sel1_pkg.sv
package sel1_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SEND = 2'd1,
    ST_WAIT = 2'd2
  } ctl_state_e;
endpackage

// File: rtl/sel1_way.sv
// One way of the cache: valid bits, tags, timestamps and blocks per set.
module sel1_way #(
  parameter int IDX_W  = 4,
  parameter int TAG_W  = 23,
  parameter int LINE_W = 256,
  parameter int TS_W   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic              rd_valid,
  output logic [TAG_W-1:0]  rd_tag,
  output logic [TS_W-1:0]   rd_ts,
  output logic [LINE_W-1:0] rd_line,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [TS_W-1:0]   wr_ts,
  input  logic [LINE_W-1:0] wr_line
);
  localparam int SETS = 1 << IDX_W;

  logic [SETS-1:0]   vld_q;
  logic [TAG_W-1:0]  tag_q  [SETS];
  logic [TS_W-1:0]   ts_q   [SETS];
  logic [LINE_W-1:0] line_q [SETS];

  always_ff @(posedge clk) begin
    if (!rst_n) vld_q <= '0;
    else if (wr_en) vld_q[wr_idx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_q[wr_idx]  <= wr_tag;
      ts_q[wr_idx]   <= wr_ts;
      line_q[wr_idx] <= wr_line;
    end
  end

  assign rd_valid = vld_q[rd_idx];
  assign rd_tag   = tag_q[rd_idx];
  assign rd_ts    = ts_q[rd_idx];
  assign rd_line  = line_q[rd_idx];
endmodule

// File: rtl/sel1_lru.sv
// Per-set recency bit for two ways: holds the way to evict next.
module sel1_lru #(
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             victim,
  input  logic             touch_en,
  input  logic [IDX_W-1:0] touch_idx,
  input  logic             touch_way
);
  localparam int SETS = 1 << IDX_W;

  logic [SETS-1:0] older_q;

  always_ff @(posedge clk) begin
    if (!rst_n) older_q <= '0;
    else if (touch_en) older_q[touch_idx] <= ~touch_way;
  end

  assign victim = older_q[rd_idx];
endmodule

// File: rtl/sel1_ctrl.sv
// Single-transaction controller: captures a miss or store and runs it to the home node.
module sel1_ctrl
  import sel1_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              core_req_valid,
  input  logic              core_req_we,
  input  logic [ADDR_W-1:0] core_req_addr,
  input  logic [WORD_W-1:0] core_req_wdata,
  input  logic              lookup_hit,
  input  logic              home_req_ready,
  input  logic              home_rsp_valid,
  output logic              core_req_ready,
  output logic              home_req_valid,
  output ctl_state_e        state,
  output logic [ADDR_W-1:0] pend_addr,
  output logic              pend_we,
  output logic [WORD_W-1:0] pend_wdata
);
  ctl_state_e state_q;
  logic       go_home;

  assign go_home = (state_q == ST_IDLE) && core_req_valid && (core_req_we || !lookup_hit);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      pend_addr  <= '0;
      pend_we    <= 1'b0;
      pend_wdata <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (go_home) begin
          state_q    <= ST_SEND;
          pend_addr  <= core_req_addr;
          pend_we    <= core_req_we;
          pend_wdata <= core_req_wdata;
        end
        ST_SEND: if (home_req_ready) state_q <= ST_WAIT;
        ST_WAIT: if (home_rsp_valid) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign state          = state_q;
  assign core_req_ready = (state_q == ST_IDLE);
  assign home_req_valid = (state_q == ST_SEND);
endmodule

// File: rtl/self_expiring_l1.sv
// Two-way L1 data cache whose lines stop hitting once shared time reaches their stamp.
module self_expiring_l1
  import sel1_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int WORD_W     = 32,
  parameter int LINE_BYTES = 32,
  parameter int SETS       = 16,
  parameter int TS_W       = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [TS_W-1:0]         now_time,
  input  logic                    core_req_valid,
  output logic                    core_req_ready,
  input  logic                    core_req_we,
  input  logic [ADDR_W-1:0]       core_req_addr,
  input  logic [WORD_W-1:0]       core_req_wdata,
  output logic                    core_rsp_valid,
  output logic [WORD_W-1:0]       core_rsp_rdata,
  output logic                    home_req_valid,
  input  logic                    home_req_ready,
  output logic                    home_req_write,
  output logic [ADDR_W-1:0]       home_req_addr,
  output logic [WORD_W-1:0]       home_req_wdata,
  input  logic                    home_rsp_valid,
  input  logic [LINE_BYTES*8-1:0] home_rsp_line,
  input  logic [TS_W-1:0]         home_rsp_ts
);
  localparam int WAYS     = 2;
  localparam int LINE_W   = LINE_BYTES * 8;
  localparam int OFF_W    = $clog2(LINE_BYTES);
  localparam int BYTE_W   = $clog2(WORD_W / 8);
  localparam int WSEL_W   = OFF_W - BYTE_W;
  localparam int IDX_W    = $clog2(SETS);
  localparam int TAG_W    = ADDR_W - OFF_W - IDX_W;

  // ---- arithmetic helpers ----
  function automatic logic stamp_passed(input logic [TS_W-1:0] t_now,
                                        input logic [TS_W-1:0] t_stamp);
    return t_now >= t_stamp;
  endfunction

  function automatic logic [WORD_W-1:0] word_of(input logic [LINE_W-1:0] blk,
                                                input logic [ADDR_W-1:0] a);
    logic [WSEL_W-1:0] sel;
    sel = a[OFF_W-1:BYTE_W];
    return blk[sel*WORD_W +: WORD_W];
  endfunction

  function automatic logic [IDX_W-1:0] set_of(input logic [ADDR_W-1:0] a);
    return a[OFF_W +: IDX_W];
  endfunction

  function automatic logic [TAG_W-1:0] tag_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1 -: TAG_W];
  endfunction

  function automatic logic [ADDR_W-1:0] line_base(input logic [ADDR_W-1:0] a);
    return {a[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
  endfunction

  // ---- controller ----
  ctl_state_e        state;
  logic [ADDR_W-1:0] pend_addr;
  logic              pend_we;
  logic [WORD_W-1:0] pend_wdata;
  logic              lookup_hit;

  sel1_ctrl #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .core_req_valid(core_req_valid),
    .core_req_we   (core_req_we),
    .core_req_addr (core_req_addr),
    .core_req_wdata(core_req_wdata),
    .lookup_hit    (lookup_hit),
    .home_req_ready(home_req_ready),
    .home_rsp_valid(home_rsp_valid),
    .core_req_ready(core_req_ready),
    .home_req_valid(home_req_valid),
    .state         (state),
    .pend_addr     (pend_addr),
    .pend_we       (pend_we),
    .pend_wdata    (pend_wdata)
  );

  // ---- lookup address: core port while idle, pending address otherwise ----
  logic [ADDR_W-1:0] cur_addr;
  logic [IDX_W-1:0]  cur_idx;
  assign cur_addr = (state == ST_IDLE) ? core_req_addr : pend_addr;
  assign cur_idx  = set_of(cur_addr);

  // ---- named internal events ----
  logic resp_done, fill_try, fill_en, fill_drop;
  logic fill_way, hit_way, lru_victim;

  logic [WAYS-1:0]   w_valid, w_live, w_match, w_hit;
  logic [TAG_W-1:0]  w_tag  [WAYS];
  logic [TS_W-1:0]   w_ts   [WAYS];
  logic [LINE_W-1:0] w_line [WAYS];

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    logic way_rd_valid;
    sel1_way #(.IDX_W(IDX_W), .TAG_W(TAG_W), .LINE_W(LINE_W), .TS_W(TS_W)) u_way (
      .clk     (clk),
      .rst_n   (rst_n),
      .rd_idx  (cur_idx),
      .rd_valid(way_rd_valid),
      .rd_tag  (w_tag[w]),
      .rd_ts   (w_ts[w]),
      .rd_line (w_line[w]),
      .wr_en   (fill_en && (fill_way == 1'(w))),
      .wr_idx  (cur_idx),
      .wr_tag  (tag_of(pend_addr)),
      .wr_ts   (home_rsp_ts),
      .wr_line (home_rsp_line)
    );
    assign w_valid[w] = way_rd_valid;
    assign w_live[w]  = way_rd_valid && !stamp_passed(now_time, w_ts[w]);
    assign w_match[w] = (w_tag[w] == tag_of(cur_addr));
    assign w_hit[w]   = w_live[w] && w_match[w];
  end

  sel1_lru #(.IDX_W(IDX_W)) u_lru (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_idx   (cur_idx),
    .victim   (lru_victim),
    .touch_en (lookup_hit || fill_en),
    .touch_idx(cur_idx),
    .touch_way(lookup_hit ? hit_way : fill_way)
  );

  assign hit_way    = ~w_hit[0];
  assign lookup_hit = (state == ST_IDLE) && core_req_valid && !core_req_we && (|w_hit);
  assign resp_done  = (state == ST_WAIT) && home_rsp_valid;
  assign fill_try   = resp_done && !pend_we;
  assign fill_en    = fill_try && !stamp_passed(now_time, home_rsp_ts);
  assign fill_drop  = fill_try && stamp_passed(now_time, home_rsp_ts);

  // Victim: same-tag way, then a dead way (way 0 first), then least recent.
  always_comb begin
    fill_way = lru_victim;
    if (!w_live[1]) fill_way = 1'b1;
    if (!w_live[0]) fill_way = 1'b0;
    if (w_valid[1] && w_match[1]) fill_way = 1'b1;
    if (w_valid[0] && w_match[0]) fill_way = 1'b0;
  end

  // ---- core response register ----
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      core_rsp_valid <= 1'b0;
      core_rsp_rdata <= '0;
    end else begin
      core_rsp_valid <= lookup_hit || resp_done;
      if (lookup_hit)
        core_rsp_rdata <= word_of(w_line[hit_way], core_req_addr);
      else if (resp_done)
        core_rsp_rdata <= pend_we ? '0 : word_of(home_rsp_line, pend_addr);
    end
  end

  // ---- home request port ----
  assign home_req_write = pend_we;
  assign home_req_addr  = pend_we ? pend_addr : line_base(pend_addr);
  assign home_req_wdata = pend_wdata;
endmodule

// File: rtl/sel1_chk.sv
// Assertion checker bound to the cache top.
module sel1_chk #(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              core_req_valid,
  input logic              core_req_ready,
  input logic              core_req_we,
  input logic              core_rsp_valid,
  input logic              home_req_valid,
  input logic              home_req_ready,
  input logic              home_req_write,
  input logic [ADDR_W-1:0] home_req_addr,
  input logic              home_rsp_valid,
  input logic              lookup_hit,
  input logic              fill_en
);
  logic accept_ld, accept_st;
  assign accept_ld = core_req_valid && core_req_ready && !core_req_we;
  assign accept_st = core_req_valid && core_req_ready && core_req_we;

  p_idle_no_home_r1: assert property (@(posedge clk) disable iff (!rst_n)
    core_req_ready |-> !home_req_valid);

  p_hit_answers_r2: assert property (@(posedge clk) disable iff (!rst_n)
    lookup_hit |=> (core_rsp_valid && core_req_ready && !home_req_valid));

  p_miss_reads_line_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_ld && !lookup_hit) |=>
      (home_req_valid && !home_req_write && (home_req_addr[OFF_W-1:0] == '0)));

  p_store_forwarded_r4: assert property (@(posedge clk) disable iff (!rst_n)
    accept_st |=> (home_req_valid && home_req_write && !core_rsp_valid));

  p_rsp_has_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
    core_rsp_valid |-> ($past(lookup_hit) || $past(home_rsp_valid)));

  p_fill_answers_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fill_en |=> core_rsp_valid);

  p_req_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (home_req_valid && !home_req_ready) |=>
      (home_req_valid && $stable(home_req_addr) && $stable(home_req_write)));
endmodule

bind self_expiring_l1 sel1_chk #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .core_req_valid(core_req_valid),
  .core_req_ready(core_req_ready),
  .core_req_we   (core_req_we),
  .core_rsp_valid(core_rsp_valid),
  .home_req_valid(home_req_valid),
  .home_req_ready(home_req_ready),
  .home_req_write(home_req_write),
  .home_req_addr (home_req_addr),
  .home_rsp_valid(home_rsp_valid),
  .lookup_hit    (lookup_hit),
  .fill_en       (fill_en)
);

// File: tb/self_expiring_l1_test.sv
`timescale 1ns/1ps
module self_expiring_l1_test;
  localparam int NSETS = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [15:0]  now_t = '0;
  logic         core_req_valid = 1'b0, core_req_we = 1'b0;
  logic [31:0]  core_req_addr = '0, core_req_wdata = '0;
  logic         core_req_ready, core_rsp_valid;
  logic [31:0]  core_rsp_rdata;
  logic         home_req_valid, home_req_write;
  logic         home_req_ready = 1'b0;
  logic [31:0]  home_req_addr, home_req_wdata;
  logic         home_rsp_valid = 1'b0;
  logic [255:0] home_rsp_line = '0;
  logic [15:0]  home_rsp_ts = '0;

  always #2 clk = ~clk;

  self_expiring_l1 uut (
    .clk(clk), .rst_n(rst_n), .now_time(now_t),
    .core_req_valid(core_req_valid), .core_req_ready(core_req_ready),
    .core_req_we(core_req_we), .core_req_addr(core_req_addr),
    .core_req_wdata(core_req_wdata), .core_rsp_valid(core_rsp_valid),
    .core_rsp_rdata(core_rsp_rdata), .home_req_valid(home_req_valid),
    .home_req_ready(home_req_ready), .home_req_write(home_req_write),
    .home_req_addr(home_req_addr), .home_req_wdata(home_req_wdata),
    .home_rsp_valid(home_rsp_valid), .home_rsp_line(home_rsp_line),
    .home_rsp_ts(home_rsp_ts)
  );

  int n_chk = 0, n_err = 0;

  // reference model of the cache contents
  bit           m_vld  [NSETS][2];
  logic [22:0]  m_tag  [NSETS][2];
  logic [15:0]  m_ts   [NSETS][2];
  logic [255:0] m_line [NSETS][2];
  bit           m_old  [NSETS];
  int           salt = 1;

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  function automatic int set_f(input logic [31:0] a); return int'(a[8:5]); endfunction
  function automatic logic [22:0] tag_f(input logic [31:0] a); return a[31:9]; endfunction
  function automatic logic [31:0] wsel(input logic [255:0] l, input logic [31:0] a);
    int i;
    i = int'(a[4:2]);
    return l[32*i +: 32];
  endfunction
  function automatic logic [255:0] mk_line(input logic [31:0] base, input int s);
    logic [255:0] l;
    for (int i = 0; i < 8; i++) l[32*i +: 32] = base ^ (s * 32'h9E37_79B9) ^ (i * 32'h0101_0101);
    return l;
  endfunction
  function automatic bit live(input int s, input int w);
    return m_vld[s][w] && (now_t < m_ts[s][w]);
  endfunction
  function automatic int hit_of(input logic [31:0] a);
    int s;
    s = set_f(a);
    for (int w = 0; w < 2; w++) if (live(s, w) && m_tag[s][w] == tag_f(a)) return w;
    return -1;
  endfunction
  function automatic int victim_of(input logic [31:0] a);
    int s;
    s = set_f(a);
    for (int w = 0; w < 2; w++) if (m_vld[s][w] && m_tag[s][w] == tag_f(a)) return w;
    for (int w = 0; w < 2; w++) if (!live(s, w)) return w;
    return int'(m_old[s]);
  endfunction

  // serve the pending home request after holding ready low for 'hold' cycles
  task automatic handshake(input int hold, input string rq);
    logic [31:0] a0;
    a0 = home_req_addr;
    for (int k = 0; k < hold; k++) begin
      @(negedge clk);
      chk(home_req_valid && home_req_addr == a0 && !core_req_ready, "R8",
          "request held while not taken", {home_req_valid, core_req_ready}, 32'h2);
    end
    home_req_ready = 1'b1;
    @(negedge clk);
    home_req_ready = 1'b0;
    chk(!home_req_valid && !core_req_ready, rq, "request dropped after handshake",
        {home_req_valid, core_req_ready}, 32'h0);
  endtask

  task automatic do_read(input logic [31:0] a, input logic [15:0] ts, input int hold,
                         input string rq);
    int hw, vw, s;
    logic [255:0] ln;
    @(negedge clk);
    chk(core_req_ready, "R8", "ready before load", core_req_ready, 1);
    core_req_valid = 1'b1; core_req_we = 1'b0; core_req_addr = a;
    hw = hit_of(a);
    s  = set_f(a);
    @(negedge clk);
    core_req_valid = 1'b0;
    if (hw >= 0) begin
      chk(core_rsp_valid && !home_req_valid, rq, "hit response",
          {core_rsp_valid, home_req_valid}, 32'h2);
      chk(core_rsp_rdata == wsel(m_line[s][hw], a), rq, "hit data",
          core_rsp_rdata, wsel(m_line[s][hw], a));
      m_old[s] = (hw == 0);
    end else begin
      chk(!core_rsp_valid && home_req_valid && !home_req_write, rq, "miss goes home",
          {core_rsp_valid, home_req_valid, home_req_write}, 32'h2);
      chk(home_req_addr == {a[31:5], 5'b0}, rq, "line-aligned read address",
          home_req_addr, {a[31:5], 5'b0});
      handshake(hold, rq);
      salt++;
      ln = mk_line({a[31:5], 5'b0}, salt);
      vw = victim_of(a);
      home_rsp_valid = 1'b1; home_rsp_line = ln; home_rsp_ts = ts;
      @(negedge clk);
      home_rsp_valid = 1'b0;
      chk(core_rsp_valid && core_rsp_rdata == wsel(ln, a), rq, "miss data returned",
          core_rsp_rdata, wsel(ln, a));
      chk(core_req_ready, "R8", "ready after response", core_req_ready, 1);
      if (now_t < ts) begin
        m_vld[s][vw] = 1'b1; m_tag[s][vw] = tag_f(a);
        m_ts[s][vw] = ts; m_line[s][vw] = ln; m_old[s] = (vw == 0);
      end
    end
  endtask

  task automatic do_write(input logic [31:0] a, input logic [31:0] d, input int hold,
                          input int gap);
    @(negedge clk);
    core_req_valid = 1'b1; core_req_we = 1'b1; core_req_addr = a; core_req_wdata = d;
    @(negedge clk);
    core_req_valid = 1'b0; core_req_we = 1'b0;
    chk(home_req_valid && home_req_write && !core_rsp_valid, "R4", "store forwarded",
        {home_req_valid, home_req_write, core_rsp_valid}, 32'h6);
    chk(home_req_addr == a && home_req_wdata == d, "R4", "store address and data",
        home_req_addr ^ home_req_wdata, a ^ d);
    handshake(hold, "R4");
    for (int k = 0; k < gap; k++) begin
      @(negedge clk);
      chk(!core_rsp_valid, "R5", "no completion before acknowledge", core_rsp_valid, 0);
    end
    home_rsp_valid = 1'b1; home_rsp_line = mk_line(32'hDEAD_0000, 7); home_rsp_ts = now_t + 16'd500;
    @(negedge clk);
    home_rsp_valid = 1'b0;
    chk(core_rsp_valid && core_rsp_rdata == 32'h0, "R5", "store completion",
        {core_rsp_valid, core_rsp_rdata[30:0]}, 32'h8000_0000);
  endtask

  function automatic logic [31:0] mk_addr(input int tg, input int st, input int wd);
    return {23'(tg), 4'(st), 3'(wd), 2'b00};
  endfunction

  initial begin
    #600000;
    n_err++;
    $display("FAIL R8 watchdog: actual hung expected finished");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [31:0] a_A, a_B;
    void'($urandom(32'd20240611));
    for (int s = 0; s < NSETS; s++) begin
      m_old[s] = 1'b0;
      for (int w = 0; w < 2; w++) m_vld[s][w] = 1'b0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk(core_req_ready && !core_rsp_valid && !home_req_valid, "R1", "reset outputs",
        {core_req_ready, core_rsp_valid, home_req_valid}, 32'h4);

    a_A = mk_addr(5, 1, 3);
    a_B = mk_addr(6, 2, 6);
    now_t = 16'd100;
    do_read(a_A, 16'd150, 0, "R1");               // cold miss, fill
    now_t = 16'd120;
    do_read(a_A ^ 32'h8, 16'd0, 0, "R2");        // other word, hit
    now_t = 16'd150;
    do_read(a_A, 16'd400, 1, "R3");              // equal to stamp: miss, refill
    now_t = 16'd200;
    do_read(a_B, 16'd200, 0, "R7");              // response already expired
    do_read(a_B, 16'd300, 2, "R7");              // therefore misses again
    do_read(a_B, 16'd0, 0, "R6");                // installed this time: hit
    do_write(a_A, 32'h1234_5678, 3, 2);          // store bypasses L1
    do_read(a_A, 16'd0, 0, "R4");                // old copy still hits
    // R9: replacement order in set 5
    now_t = 16'd1000;
    do_read(mk_addr(10, 5, 0), 16'd5000, 0, "R9");
    do_read(mk_addr(11, 5, 1), 16'd5000, 0, "R9");
    do_read(mk_addr(10, 5, 2), 16'd0, 0, "R9");  // hit, way 1 becomes oldest
    do_read(mk_addr(12, 5, 3), 16'd5000, 0, "R9"); // evicts tag 11
    do_read(mk_addr(10, 5, 4), 16'd0, 0, "R9");  // still present
    do_read(mk_addr(11, 5, 5), 16'd5000, 0, "R9"); // evicted: miss

    // random phase
    now_t = 16'd2000;
    for (int n = 0; n < 400; n++) begin
      logic [31:0] ra;
      ra = mk_addr(int'($urandom_range(1, 3)), ($urandom_range(0, 1) != 0) ? 3 : 7,
                   int'($urandom_range(0, 7)));
      if ($urandom_range(0, 3) == 0) now_t = now_t + 16'($urandom_range(0, 20));
      if ($urandom_range(0, 4) == 0)
        do_write(ra, $urandom, int'($urandom_range(0, 2)), int'($urandom_range(0, 2)));
      else
        do_read(ra, now_t + 16'($urandom_range(0, 60)), int'($urandom_range(0, 2)), "R6");
    end

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule